// File: doc/BRIEF.md
# Latched Real-Time Clock with Watchdog

This peripheral keeps a free-running 24-bit time count and a watchdog timer behind a 16-bit processor bus. A prescaler divides the system clock into ticks, and each tick advances the time count. Software reads the count as three byte registers. A read of the low byte returns the live low byte and copies the whole count into a snapshot register. The middle and upper byte registers return that snapshot, so a read that starts with the low byte and then takes the other two bytes sees one consistent value.

Two write-only strobe addresses act on the timers. A write to one clears the prescaler and the time count. A write to the other restarts the watchdog. The data written to either address is ignored. If the watchdog is not restarted within a set number of system clock cycles, the block emits a one-cycle timeout pulse and begins counting again. While the power-down input is high, the timers keep running but the block ignores every bus access.

Top module: `latched_rtc`

## Requirements
- R1: Address 0 returns the live count bits 7:0 and address 1 and address 2 return snapshot bytes. Read data appears on busRdata[15:8] in the cycle after the read strobe, and busRdata[7:0] is always zero.
- R2: A read of address 0 captures the whole count into the snapshot. Reads of addresses 1 and 2 return snapshot bits 15:8 and 23:16, not the live count. Any other cycle leaves the snapshot unchanged.
- R3: A write to address 3 clears both the prescaler and the count at that edge, whatever the data. After the clear, the count advances by one every PRESCALE clock cycles.
- R4: A write to address 4 restarts the watchdog at that edge, whatever the data.
- R5: wdTimeout pulses high for exactly one cycle, WD_CYCLES cycles after the last restart. The watchdog then restarts by itself and pulses again after another WD_CYCLES cycles.
- R6: While powerDown is high, reads return zero and take no snapshot, and writes to addresses 3 and 4 have no effect. The count and the watchdog keep running.
- R7: After reset, busRdata and wdTimeout are zero, and the count, the snapshot and the watchdog start at zero.
- R8: busRdata is zero in any cycle that follows no read, or that follows a read of an unmapped address (5 to 7).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register address |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busWdata | input | 16 | Write data; no register uses it |
| powerDown | input | 1 | High blocks all bus accesses |
| busRdata | output | 16 | Registered read data, byte on bits 15:8 |
| wdTimeout | output | 1 | One-cycle watchdog expiry pulse |

## Verification
Read data is registered, so each read result is due one clock after the edge that samples the strobe. The bench drives at the falling edge and compares queued expectations at the next falling edge. A clear written at edge r sets the count sampled by a read at edge n to floor((n-1-r)/PRESCALE). The bench computes this from its own edge counter, and it issues clears at different prescaler phases. After a restart at edge k, the timeout pulse is due at the falling edge after edge k+WD_CYCLES and must be gone one cycle later. The bench counts edges to that exact point and checks that wdTimeout stays low before it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BUS_W      = 16;
  localparam int ADDR_W     = 3;
  localparam int BYTE_W     = 8;
  localparam int TIME_BYTES = 3;
  localparam int TIME_W     = BYTE_W * TIME_BYTES;
  localparam int SEL_W      = $clog2(TIME_BYTES);

  typedef enum logic [ADDR_W-1:0] {
    ADDR_TIME_LO  = 3'd0,
    ADDR_TIME_MID = 3'd1,
    ADDR_TIME_HI  = 3'd2,
    ADDR_CLR_TIME = 3'd3,
    ADDR_KICK_WD  = 3'd4
  } rtcAddr_e;

  // Strobes from the bus decoder to the datapath
  typedef struct packed {
    logic             rdEn;
    logic [SEL_W-1:0] rdByte;
    logic             snapTake;
    logic             clrTime;
    logic             kickWd;
  } rtcStrobe_t;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              powerDown,
  output rtcStrobe_t        stb
);
  logic access;
  assign access = !powerDown;

  always_comb begin
    stb = '0;
    if (access && busRd) begin
      case (rtcAddr_e'(busAddr))
        ADDR_TIME_LO: begin
          stb.rdEn     = 1'b1;
          stb.rdByte   = SEL_W'(0);
          stb.snapTake = 1'b1;
        end
        ADDR_TIME_MID: begin
          stb.rdEn   = 1'b1;
          stb.rdByte = SEL_W'(1);
        end
        ADDR_TIME_HI: begin
          stb.rdEn   = 1'b1;
          stb.rdByte = SEL_W'(2);
        end
        default: ;
      endcase
    end
    if (access && busWr) begin
      case (rtcAddr_e'(busAddr))
        ADDR_CLR_TIME: stb.clrTime = 1'b1;
        ADDR_KICK_WD:  stb.kickWd  = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int PRESCALE  = 4,
  parameter int WD_CYCLES = 1000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  rtcStrobe_t              stb,
  output logic [BUS_W-1:0]        busRdata,
  output logic                    wdTimeout,
  output logic [TIME_W-1:0]       timeCount,
  output logic [TIME_W-1:BYTE_W]  snapBytes
);
  localparam int PRE_W = $clog2(PRESCALE > 1 ? PRESCALE : 2);
  localparam int WD_W  = $clog2(WD_CYCLES + 1);

  // Prescaler and time counter
  logic [PRE_W-1:0] preCnt;
  logic             tick;
  assign tick = (preCnt == PRE_W'(PRESCALE - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt    <= '0;
      timeCount <= '0;
    end else if (stb.clrTime) begin
      preCnt    <= '0;
      timeCount <= '0;
    end else begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
      if (tick) timeCount <= timeCount + 1'b1;
    end
  end

  // Snapshot of the upper bytes, taken on a low-byte read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             snapBytes <= '0;
    else if (stb.snapTake) snapBytes <= timeCount[TIME_W-1:BYTE_W];
  end

  // Byte lanes: lane 0 is live, the others come from the snapshot
  logic [BYTE_W-1:0] lane [TIME_BYTES];
  for (genvar b = 0; b < TIME_BYTES; b++) begin : gLane
    if (b == 0) begin : gLive
      assign lane[b] = timeCount[BYTE_W-1:0];
    end else begin : gSnap
      assign lane[b] = snapBytes[b*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         busRdata <= '0;
    else if (stb.rdEn) busRdata <= {lane[stb.rdByte], {(BUS_W-BYTE_W){1'b0}}};
    else               busRdata <= '0;
  end

  // Watchdog
  logic [WD_W-1:0] wdCnt;
  logic            wdLast;
  assign wdLast = (wdCnt == WD_W'(WD_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdCnt     <= '0;
      wdTimeout <= 1'b0;
    end else begin
      wdTimeout <= wdLast && !stb.kickWd;
      if (stb.kickWd || wdLast) wdCnt <= '0;
      else                      wdCnt <= wdCnt + 1'b1;
    end
  end
endmodule

// File: rtl/latched_rtc.sv
module latched_rtc
  import rtc_pkg::*;
#(
  parameter int PRESCALE  = 4,
  parameter int WD_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [BUS_W-1:0]  busWdata,
  input  logic              powerDown,
  output logic [BUS_W-1:0]  busRdata,
  output logic              wdTimeout
);
  rtcStrobe_t                stb;
  logic [TIME_W-1:0]         timeCount;
  logic [TIME_W-1:BYTE_W]    snapBytes;
  logic                      wdataUnused;

  // The strobe registers take no data
  assign wdataUnused = ^busWdata;

  rtc_ctrl ctrl_i (
    .busRd     (busRd),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .powerDown (powerDown),
    .stb       (stb)
  );

  rtc_datapath #(
    .PRESCALE  (PRESCALE),
    .WD_CYCLES (WD_CYCLES)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busRdata  (busRdata),
    .wdTimeout (wdTimeout),
    .timeCount (timeCount),
    .snapBytes (snapBytes)
  );
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
  import rtc_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic [ADDR_W-1:0]      busAddr,
  input logic                   busRd,
  input logic                   busWr,
  input logic                   powerDown,
  input logic [BUS_W-1:0]       busRdata,
  input logic                   wdTimeout,
  input logic [TIME_W-1:0]      timeCount,
  input logic [TIME_W-1:BYTE_W] snapBytes
);
  logic clrReq, kickReq, loReq;
  assign clrReq  = busWr && (busAddr == ADDR_CLR_TIME) && !powerDown;
  assign kickReq = busWr && (busAddr == ADDR_KICK_WD) && !powerDown;
  assign loReq   = busRd && (busAddr == ADDR_TIME_LO) && !powerDown;

  assert_low_lane_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[BYTE_W-1:0] == '0);

  assert_snap_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !loReq |=> $stable(snapBytes));

  assert_clear_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    clrReq |=> timeCount == '0);

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    !clrReq |=> (TIME_W'(timeCount - $past(timeCount)) <= TIME_W'(1)));

  assert_kick_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    kickReq |=> !wdTimeout);

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    wdTimeout |=> !wdTimeout);

  assert_pd_read_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> busRdata == '0);

  assert_idle_rdata_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> busRdata == '0);
endmodule

bind latched_rtc rtc_checker chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busRd     (busRd),
  .busWr     (busWr),
  .powerDown (powerDown),
  .busRdata  (busRdata),
  .wdTimeout (wdTimeout),
  .timeCount (timeCount),
  .snapBytes (snapBytes)
);

// File: tb/latched_rtc_tb_top.sv
module latched_rtc_tb_top;
  localparam int P = 2;
  localparam int T = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [15:0] busWdata = '0;
  logic        powerDown = 1'b0;
  logic [15:0] busRdata;
  logic        wdTimeout;

  always #5 clk = ~clk;

  latched_rtc #(.PRESCALE(P), .WD_CYCLES(T)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .powerDown(powerDown), .busRdata(busRdata),
    .wdTimeout(wdTimeout)
  );

  int nRun = 0;
  int nFail = 0;
  int cyc = 0;
  int clrEdge = 0;
  logic [23:0] snapModel = '0;
  logic [15:0] expQ[$];
  string       tagQ[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Count value sampled by a read at the coming edge
  function automatic logic [23:0] liveCount();
    return 24'((cyc - clrEdge) / P);
  endfunction

  // Monitor: compares queued expectations one cycle after each read
  initial begin
    forever begin
      logic issued;
      @(posedge clk);
      issued = busRd;
      @(negedge clk);
      if (issued && expQ.size() > 0) check(tagQ.pop_front(), busRdata, expQ.pop_front());
    end
  end

  task automatic busRead(input logic [2:0] addr, input logic [15:0] exp, input string tag);
    busAddr = addr;
    busRd   = 1'b1;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  // Low byte read with model of the snapshot
  task automatic readLow(input string tag);
    logic [23:0] v;
    v = liveCount();
    if (!powerDown) snapModel = v;
    busRead(3'd0, powerDown ? 16'h0 : {v[7:0], 8'h00}, tag);
  endtask

  task automatic busWrite(input logic [2:0] addr, input logic [15:0] data);
    busAddr  = addr;
    busWdata = data;
    busWr    = 1'b1;
    if (addr == 3'd3 && !powerDown) clrEdge = cyc + 1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Expect the timeout pulse after edge pulseEdge and nowhere before it
  task automatic waitPulse(input int pulseEdge, input string tag);
    logic early;
    early = 1'b0;
    while (cyc < pulseEdge) begin
      if (wdTimeout) early = 1'b1;
      @(negedge clk);
    end
    check({tag, " quiet before expiry"}, 16'(early), 16'h0);
    check({tag, " pulse"}, 16'(wdTimeout), 16'h1);
    @(negedge clk);
    check({tag, " one cycle"}, 16'(wdTimeout), 16'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int k;
    idle(3);
    rstN = 1'b1;
    // R7: reset state
    check("R7 rdata", busRdata, 16'h0);
    check("R7 timeout", 16'(wdTimeout), 16'h0);
    busRead(3'd1, 16'h0, "R7 snapshot mid");
    busRead(3'd2, 16'h0, "R7 snapshot high");
    idle(2);

    // R3: clear at different phases and data values, then step timing
    busWrite(3'd3, 16'hFFFF);
    for (int i = 0; i < 5; i++) readLow("R3 count after clear");
    idle(3);
    busWrite(3'd3, 16'h1234);
    for (int i = 0; i < 6; i++) readLow("R3 count phase two");
    idle(4);
    busWrite(3'd3, 16'h0000);
    idle(1);
    readLow("R1 live low byte");
    // R8: idle cycle and unmapped address
    idle(1);
    check("R8 idle rdata", busRdata, 16'h0);
    busRead(3'd6, 16'h0, "R8 unmapped read");

    // R2: snapshot versus live count
    busWrite(3'd3, 16'h0);
    idle(600);
    readLow("R2 low read");
    idle(600);
    busRead(3'd1, {snapModel[15:8], 8'h0}, "R2 mid from snapshot");
    busRead(3'd2, {snapModel[23:16], 8'h0}, "R1 high byte");

    // R6: power-down blocks access, timers keep running
    idle(600);
    powerDown = 1'b1;
    readLow("R6 read blocked");
    busRead(3'd1, 16'h0, "R6 mid blocked");
    busWrite(3'd3, 16'h5555);
    powerDown = 1'b0;
    busRead(3'd1, {snapModel[15:8], 8'h0}, "R6 snapshot untouched");
    readLow("R6 counter kept running");
    idle(1);

    // R4 and R5: restart and expiry
    busWrite(3'd4, 16'hABCD);
    k = cyc;
    waitPulse(k + T, "R4 kick");
    waitPulse(k + 2 * T, "R5 auto restart");
    busWrite(3'd4, 16'h0000);
    k = cyc;
    idle(10);
    powerDown = 1'b1;
    busWrite(3'd4, 16'hFFFF);
    powerDown = 1'b0;
    waitPulse(k + T, "R6 kick ignored");

    // R1 and R2: high byte from a long run
    busWrite(3'd3, 16'h0);
    idle(131200);
    readLow("R2 low read late");
    busRead(3'd2, {snapModel[23:16], 8'h0}, "R1 high byte nonzero");
    busRead(3'd1, {snapModel[15:8], 8'h0}, "R2 mid late");
    idle(2);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule